// File: doc/BRIEF.md
# Power-Fail Cache Flush Controller

This block sequences a write-back cache that is backed by stored energy. It watches a power-fail interrupt, a health code from the energy store, the number of dirty cache lines, and a done handshake from a flush engine. From these it decides whether the cache may run in write-back mode, whether host writes may enter, and when each write is acknowledged.

When power fails, host writes are refused at once. Metadata regions go to media first, then dirty data, and a completion marker is then written. The block then parks in a safe state. A cycle budget bounds the flush. If the budget runs out, the block parks without writing the marker, and the logged outcome shows an incomplete flush. The cache array, the drives and the energy store are modelled outside the block.

Top module: `pf_flush_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `wb_mode`, `flush_req`, `marker_wr`, `safe_state`, `pf_log_valid` and `host_ack` are 0.
- R2: `wb_mode` can become 1 only while `health` is 0 (good). The codes 1 (marginal), 2 (learning) and 3 (over temperature) never allow write-back.
- R3: If health turns bad while `wb_mode` is 1 and `dirty_cnt` is nonzero, `host_wr_ready` drops and `flush_req` is raised with `flush_is_meta` 0 until `dirty_cnt` is 0. `wb_mode` then becomes 0 one cycle later. With `dirty_cnt` 0, the switch takes one cycle.
- R4: In write-back mode a write accepted with `host_wr_valid` and `host_wr_ready` both 1 is acknowledged by `host_ack` in the next cycle.
- R5: In write-through mode an accepted write is not acknowledged on acceptance. `host_ack` pulses in the cycle after `media_done` is 1.
- R6: `host_wr_ready` is 0 in the same cycle that `pfi` is 1, and it stays 0 for the rest of the power-fail sequence. No `host_ack` occurs during that sequence.
- R7: After `pfi`, one stop cycle with no flush request follows. The block then requests metadata (`flush_req` 1, `flush_is_meta` 1) until `flush_done`, and after that requests data (`flush_is_meta` 0) while `dirty_cnt` is nonzero. When `dirty_cnt` is 0 the data phase is left without a request.
- R8: When the data phase finishes, `marker_wr` pulses for one cycle. In the next cycle `safe_state` is 1 and `pf_log_valid` pulses with `pf_log_ok` 1.
- R9: The flush budget is loaded with FLUSH_BUDGET when the flush starts. If the budget expires before the marker phase, the block enters the safe state without a marker, and `pf_log_valid` pulses with `pf_log_ok` 0.
- R10: `safe_state` stays 1 until reset, whatever `pfi` does, and `host_wr_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfi | input | 1 | Power-fail interrupt |
| health | input | 2 | Energy store health code, 0 means good |
| dirty_cnt | input | CW | Number of dirty cache lines |
| flush_done | input | 1 | Flush engine finished the requested region |
| host_wr_valid | input | 1 | Host offers a write |
| media_done | input | 1 | Media commit of a write-through write |
| host_wr_ready | output | 1 | Host write may be taken |
| host_ack | output | 1 | Write acknowledge pulse |
| wb_mode | output | 1 | 1 write-back, 0 write-through |
| flush_req | output | 1 | Request to the flush engine |
| flush_is_meta | output | 1 | The request is for metadata regions |
| marker_wr | output | 1 | Write the flush-complete marker |
| safe_state | output | 1 | Parked after a power fail |
| pf_log_valid | output | 1 | Power-fail outcome record pulse |
| pf_log_ok | output | 1 | Outcome: 1 complete, 0 incomplete |

## Verification
The mode gate is tried with sequences of health codes and dirty counts. These separate an immediate switch to write-through from a drain-first switch, and show that a bad health code in write-through mode starts no drain. The power-fail path is tried three ways: with dirty data and an engine that answers, with no dirty data, and with an engine that never answers. These cases tell the metadata-before-data order, the skipped data phase and the budget expiry apart. The acknowledge tests contrast acknowledge on acceptance with acknowledge on media commit.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL, ST_PF_STOP, ST_FLUSH_META, ST_FLUSH_DATA, ST_MARK_DONE, ST_SAFE
  } pf_state_t;
  localparam logic [1:0] HLTH_OK = 2'd0;
endpackage

// File: rtl/pf_mode_gate.sv
module pf_mode_gate #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_normal,
  input  logic [1:0]    health,
  input  logic [CW-1:0] dirty_cnt,
  output logic          wb_mode,
  output logic          draining
);
  import pf_pkg::*;
  logic wb_q, wb_d, hlth_ok;

  always_comb begin
    hlth_ok  = (health == HLTH_OK);
    draining = wb_q & ~hlth_ok & in_normal;
    wb_d     = wb_q;
    if (in_normal) begin
      if (wb_q && !hlth_ok && dirty_cnt == '0) wb_d = 1'b0;
      else if (!wb_q && hlth_ok)                wb_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wb_q <= 1'b0;
    else        wb_q <= wb_d;
  end

  assign wb_mode = wb_q;
endmodule

// File: rtl/pf_budget.sv
module pf_budget #(
  parameter int FLUSH_BUDGET = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int BW = $clog2(FLUSH_BUDGET + 1);
  localparam logic [BW-1:0] BUDGET_V = BW'(FLUSH_BUDGET);
  logic [BW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = BUDGET_V;
    else if (run && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/pf_seq.sv
module pf_seq (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfi,
  input  logic              dirty_zero,
  input  logic              flush_done,
  input  logic              expired,
  output pf_pkg::pf_state_t state,
  output logic              log_valid,
  output logic              log_ok
);
  import pf_pkg::*;
  pf_state_t st_q, st_d;
  logic      lv_d, lok_d, lv_q, lok_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_NORMAL:     if (pfi) st_d = ST_PF_STOP;
      ST_PF_STOP:    st_d = ST_FLUSH_META;
      ST_FLUSH_META: if (expired) st_d = ST_SAFE;
                     else if (flush_done) st_d = ST_FLUSH_DATA;
      ST_FLUSH_DATA: if (expired) st_d = ST_SAFE;
                     else if (dirty_zero || flush_done) st_d = ST_MARK_DONE;
      ST_MARK_DONE:  st_d = ST_SAFE;
      default:       st_d = ST_SAFE;
    endcase
    lv_d  = (st_q != ST_SAFE) && (st_d == ST_SAFE);
    lok_d = lv_d ? (st_q == ST_MARK_DONE) : lok_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_NORMAL;
      lv_q  <= 1'b0;
      lok_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      lv_q  <= lv_d;
      lok_q <= lok_d;
    end
  end

  assign state     = st_q;
  assign log_valid = lv_q;
  assign log_ok    = lok_q;
endmodule

// File: rtl/pf_flush_ctrl.sv
module pf_flush_ctrl #(
  parameter int CW           = 8,
  parameter int FLUSH_BUDGET = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pfi,
  input  logic [1:0]    health,
  input  logic [CW-1:0] dirty_cnt,
  input  logic          flush_done,
  input  logic          host_wr_valid,
  input  logic          media_done,
  output logic          host_wr_ready,
  output logic          host_ack,
  output logic          wb_mode,
  output logic          flush_req,
  output logic          flush_is_meta,
  output logic          marker_wr,
  output logic          safe_state,
  output logic          pf_log_valid,
  output logic          pf_log_ok
);
  import pf_pkg::*;
  logic [1:0] rst_sync_q;
  logic       rst_i, in_normal, draining, dirty_zero, expired, ack_d, ack_q;
  pf_state_t  state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign dirty_zero = (dirty_cnt == '0);
  assign in_normal  = (state == ST_NORMAL);

  pf_mode_gate #(.CW(CW)) u_gate (
    .clk(clk), .rst_n(rst_i), .in_normal(in_normal), .health(health),
    .dirty_cnt(dirty_cnt), .wb_mode(wb_mode), .draining(draining)
  );

  pf_budget #(.FLUSH_BUDGET(FLUSH_BUDGET)) u_budget (
    .clk(clk), .rst_n(rst_i), .load(state == ST_PF_STOP),
    .run(state == ST_FLUSH_META || state == ST_FLUSH_DATA), .expired(expired)
  );

  pf_seq u_seq (
    .clk(clk), .rst_n(rst_i), .pfi(pfi), .dirty_zero(dirty_zero),
    .flush_done(flush_done), .expired(expired), .state(state),
    .log_valid(pf_log_valid), .log_ok(pf_log_ok)
  );

  assign host_wr_ready = in_normal & ~pfi & ~draining;

  always_comb begin
    if (wb_mode) ack_d = host_wr_valid & host_wr_ready;
    else         ack_d = media_done & in_normal & ~pfi;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end
  assign host_ack = ack_q;

  assign flush_req = (in_normal & draining & ~dirty_zero & ~pfi)
                   | (state == ST_FLUSH_META)
                   | (state == ST_FLUSH_DATA & ~dirty_zero);
  assign flush_is_meta = (state == ST_FLUSH_META);
  assign marker_wr     = (state == ST_MARK_DONE);
  assign safe_state    = (state == ST_SAFE);
endmodule

// File: rtl/pf_flush_chk.sv
module pf_flush_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pfi,
  input logic [1:0] health,
  input logic       host_wr_ready,
  input logic       wb_mode,
  input logic       dirty_zero,
  input logic       marker_wr,
  input logic       safe_state,
  input logic       pf_log_valid,
  input logic       pf_log_ok
);
  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfi |-> !host_wr_ready);
  // R2
  wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_mode) |-> $past(health) == 2'd0);
  // R3
  drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wb_mode) |-> $past(dirty_zero));
  // R8
  marker_then_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    marker_wr |=> safe_state && pf_log_valid && pf_log_ok);
  // R9
  no_marker_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_log_valid && !pf_log_ok) |-> !$past(marker_wr));
  // R10
  safe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    safe_state |=> safe_state && !host_wr_ready);
endmodule

bind pf_flush_ctrl pf_flush_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pfi(pfi), .health(health),
  .host_wr_ready(host_wr_ready), .wb_mode(wb_mode), .dirty_zero(dirty_zero),
  .marker_wr(marker_wr), .safe_state(safe_state),
  .pf_log_valid(pf_log_valid), .pf_log_ok(pf_log_ok)
);

// File: tb/sim_pf_flush_ctrl.sv
module sim_pf_flush_ctrl;
  localparam int CW = 8;
  localparam int BUDGET = 16;

  logic clk = 1'b0;
  logic rst_n, pfi, flush_done, host_wr_valid, media_done;
  logic [1:0] health;
  logic [CW-1:0] dirty_cnt;
  logic host_wr_ready, host_ack, wb_mode, flush_req, flush_is_meta;
  logic marker_wr, safe_state, pf_log_valid, pf_log_ok;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pf_flush_ctrl #(.CW(CW), .FLUSH_BUDGET(BUDGET)) u0 (
    .clk(clk), .rst_n(rst_n), .pfi(pfi), .health(health), .dirty_cnt(dirty_cnt),
    .flush_done(flush_done), .host_wr_valid(host_wr_valid), .media_done(media_done),
    .host_wr_ready(host_wr_ready), .host_ack(host_ack), .wb_mode(wb_mode),
    .flush_req(flush_req), .flush_is_meta(flush_is_meta), .marker_wr(marker_wr),
    .safe_state(safe_state), .pf_log_valid(pf_log_valid), .pf_log_ok(pf_log_ok)
  );

  // {health, dirty, exp wb_mode, exp flush_req, exp host_wr_ready}
  localparam logic [12:0] VEC [9] = '{
    {2'd0, 8'd0, 1'b1, 1'b0, 1'b1},
    {2'd1, 8'd0, 1'b0, 1'b0, 1'b1},
    {2'd0, 8'd3, 1'b1, 1'b0, 1'b1},
    {2'd2, 8'd3, 1'b1, 1'b1, 1'b0},
    {2'd2, 8'd0, 1'b0, 1'b0, 1'b1},
    {2'd3, 8'd5, 1'b0, 1'b0, 1'b1},
    {2'd0, 8'd5, 1'b1, 1'b0, 1'b1},
    {2'd3, 8'd5, 1'b1, 1'b1, 1'b0},
    {2'd3, 8'd0, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] h, input logic [CW-1:0] d);
    rst_n = 1'b0; pfi = 1'b0; flush_done = 1'b0; host_wr_valid = 1'b0;
    media_done = 1'b0; health = h; dirty_cnt = d;
    tick(3);
    rst_n = 1'b1;
    tick(4);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pfi = 1'b0; flush_done = 1'b0; host_wr_valid = 1'b0;
    media_done = 1'b0; health = 2'd3; dirty_cnt = '0;
    tick(2);
    // R1 reset state
    chk("R1 wb_mode", wb_mode, 0);
    chk("R1 flush_req", flush_req, 0);
    chk("R1 marker/safe/log", {marker_wr, safe_state, pf_log_valid, host_ack}, 0);
    do_reset(2'd3, '0);
    chk("R1 wb_mode after reset, bad health", wb_mode, 0);

    // R2 / R3 table
    for (int k = 0; k < 9; k++) begin
      health = VEC[k][12:11]; dirty_cnt = VEC[k][10:3];
      tick(2);
      chk($sformatf("R2 wb_mode vec%0d", k), wb_mode, VEC[k][2]);
      chk($sformatf("R3 flush_req vec%0d", k), flush_req, VEC[k][1]);
      chk($sformatf("R3 ready vec%0d", k), host_wr_ready, VEC[k][0]);
    end

    // R4 write-back ack
    health = 2'd0; dirty_cnt = '0; tick(2);
    host_wr_valid = 1'b1; #1 chk("R4 ready", host_wr_ready, 1);
    tick(1); host_wr_valid = 1'b0;
    chk("R4 ack after accept", host_ack, 1);
    tick(1); chk("R4 ack single pulse", host_ack, 0);

    // R5 write-through ack
    health = 2'd1; tick(2);
    chk("R5 in write-through", wb_mode, 0);
    host_wr_valid = 1'b1; tick(1); host_wr_valid = 1'b0;
    chk("R5 no ack on accept", host_ack, 0);
    media_done = 1'b1; tick(1); media_done = 1'b0;
    chk("R5 ack after media", host_ack, 1);

    // power fail with dirty data
    do_reset(2'd0, 8'd4);
    chk("R2 wb on good health", wb_mode, 1);
    host_wr_valid = 1'b1; pfi = 1'b1;
    #1 chk("R6 ready drops with pfi", host_wr_ready, 0);
    tick(1);
    chk("R7 stop cycle no request", flush_req, 0);
    chk("R6 no ack", host_ack, 0);
    tick(1);
    chk("R7 meta first", {flush_req, flush_is_meta}, 2'b11);
    tick(2);
    chk("R7 meta held", {flush_req, flush_is_meta}, 2'b11);
    flush_done = 1'b1; tick(1); flush_done = 1'b0;
    chk("R7 data after meta", {flush_req, flush_is_meta}, 2'b10);
    chk("R6 still no ready/ack", {host_wr_ready, host_ack}, 0);
    dirty_cnt = '0; flush_done = 1'b1; tick(1); flush_done = 1'b0;
    chk("R8 marker", marker_wr, 1);
    tick(1);
    chk("R8 safe+log ok", {safe_state, pf_log_valid, pf_log_ok}, 3'b111);
    pfi = 1'b0; host_wr_valid = 1'b0; tick(1);
    chk("R8 log single pulse", pf_log_valid, 0);
    tick(5);
    chk("R10 safe sticky", {safe_state, host_wr_ready}, 2'b10);

    // write-through, no dirty: data phase skipped
    do_reset(2'd1, '0);
    pfi = 1'b1; tick(2); pfi = 1'b0;
    chk("R7 meta in WT", {flush_req, flush_is_meta}, 2'b11);
    flush_done = 1'b1; tick(1); flush_done = 1'b0;
    chk("R7 no data request when clean", {flush_req, flush_is_meta}, 2'b00);
    tick(1);
    chk("R7 straight to marker", marker_wr, 1);

    // budget expiry
    do_reset(2'd1, '0);
    pfi = 1'b1; tick(2);
    tick(10);
    chk("R9 still flushing inside budget", {safe_state, flush_req}, 2'b01);
    begin
      logic seen_marker;
      seen_marker = 1'b0;
      for (int c = 0; c < 40 && !safe_state; c++) begin
        if (marker_wr) seen_marker = 1'b1;
        tick(1);
      end
      chk("R9 safe on expiry", safe_state, 1);
      chk("R9 no marker", seen_marker, 0);
      chk("R9 log incomplete", {pf_log_valid, pf_log_ok}, 2'b10);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule